// File: doc/BRIEF.md
# Credit-Flow Stream Link

This block joins a data producer to a data consumer over a stream channel that is paced by credits, not by a per-beat ready handshake. The receiving side owns a small buffer. It announces free room by raising an update strobe together with a count on a credit bus. The sending side adds each announced count to a counter, and it launches a beat only while that counter is non-zero. Each launched beat spends one credit. The sender may also hand unused credits back, one per cycle, through a return strobe.

Because every beat on the channel was paid for in advance, the receiver accepts every arriving beat unconditionally. The receiver never grants more room than it has. Credits it has granted but not yet seen used or returned count as taken, so a beat always finds a free slot. Users push words in at the sending port and drain them in arrival order at the receiving port. A pop request only takes effect while the buffer holds data.

Top module: `credit_stream_link`

## Requirements
- R1: While reset is held, the credit count reads 0, and `link_valid`, `link_update` and `snk_out_valid` are all low.
- R2: Whenever the free room of the receiver is non-zero, it raises `link_update` in the same cycle with `link_credit` = min(free room, CREDIT_MAX). Free room is DEPTH minus the words held minus the credits outstanding. With no free room, `link_update` stays low. Starting from reset with the defaults (DEPTH 8, CREDIT_MAX 4), the count reaches 8 two clock edges after reset is released.
- R3: At each clock edge, the credit count becomes its old value, plus `link_credit` if `link_update` was high, minus 1 if `link_valid` was high, minus 1 if `link_return` was high.
- R4: `link_valid` is high only when `src_in_valid` is high and the registered credit count is non-zero. Credits that arrive in the same cycle cannot enable a beat while the count is 0.
- R5: Each cycle with `src_give_back` high returns exactly one credit, shown on `link_return`. The return is suppressed unless the count exceeds the beats sent in that cycle, so a request at zero credits has no effect.
- R6: Words held plus credits outstanding never exceed DEPTH. Every credited beat is stored, and no beat is lost.
- R7: `snk_out_valid` is high while the buffer holds data, and `snk_out_data` presents words in the order they were accepted. A pop on an empty buffer has no effect.
- R8: `src_in_accept` equals `link_valid`. With the consumer popping every cycle, the producer sustains one beat per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in_valid | input | 1 | Producer has a word to send |
| src_in_data | input | DATA_W | Producer word |
| src_in_accept | output | 1 | Word taken this cycle |
| src_give_back | input | 1 | Request to return one unused credit |
| src_credits | output | CNT_W | Current credit count of the sender |
| link_update | output | 1 | Receiver grants credits this cycle |
| link_credit | output | CREDIT_W | Number of credits granted |
| link_valid | output | 1 | Beat on the channel this cycle |
| link_return | output | 1 | One credit handed back this cycle |
| snk_out_valid | output | 1 | Receiver buffer holds a word |
| snk_out_data | output | DATA_W | Oldest buffered word |
| snk_out_pop | input | 1 | Consumer removes the oldest word |

## Verification
A grant is visible on `link_update` in the same cycle as the free room that causes it, and it lands in `src_credits` one edge later. A beat accepted at an edge shows at `snk_out_data` right after that edge. A returned credit is granted again in the following cycle. The bench drives inputs on the falling edge and samples 2 ns later. Each expected value is placed in the window after the number of rising edges listed above, and a monitor re-derives the counter arithmetic in every cycle.

// File: rtl/credit_stream_link.sv
module credit_stream_link #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 8,
  parameter int CREDIT_MAX = 4,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int CREDIT_W  = $clog2(CREDIT_MAX + 1),
  localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_in_valid,
  input  logic [DATA_W-1:0]   src_in_data,
  output logic                src_in_accept,
  input  logic                src_give_back,
  output logic [CNT_W-1:0]    src_credits,
  output logic                link_update,
  output logic [CREDIT_W-1:0] link_credit,
  output logic                link_valid,
  output logic                link_return,
  output logic                snk_out_valid,
  output logic [DATA_W-1:0]   snk_out_data,
  input  logic                snk_out_pop
);

  // sending side
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gain;

  assign src_credits   = cnt_q;
  assign link_valid    = src_in_valid && (cnt_q != '0);
  assign src_in_accept = link_valid;
  assign link_return   = src_give_back && (cnt_q > CNT_W'(link_valid));
  assign gain          = link_update ? CNT_W'(link_credit) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + gain - CNT_W'(link_valid) - CNT_W'(link_return);
  end

  // receiving side
  logic [CNT_W-1:0]  occ, owed;
  logic [CNT_W:0]    free_w;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              pop;

  assign free_w      = (CNT_W+1)'(DEPTH) - {1'b0, occ} - {1'b0, owed};
  assign link_update = rst_n && (free_w != '0);
  assign link_credit = (free_w > (CNT_W+1)'(CREDIT_MAX)) ? CREDIT_W'(CREDIT_MAX)
                                                         : CREDIT_W'(free_w);
  assign pop           = snk_out_pop && (occ != '0);
  assign snk_out_valid = (occ != '0);
  assign snk_out_data  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      owed   <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      occ  <= occ + CNT_W'(link_valid) - CNT_W'(pop);
      owed <= owed + gain - CNT_W'(link_valid) - CNT_W'(link_return);
      if (link_valid) wr_ptr <= nxt(wr_ptr);
      if (pop)        rd_ptr <= nxt(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (link_valid) mem[wr_ptr] <= src_in_data;
  end

endmodule

// File: rtl/credit_stream_link_chk.sv
module credit_stream_link_chk #(
  parameter int DEPTH      = 8,
  parameter int CREDIT_MAX = 4,
  parameter int CNT_W      = 4,
  parameter int CREDIT_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                src_in_valid,
  input logic [CNT_W-1:0]    src_credits,
  input logic                link_update,
  input logic [CREDIT_W-1:0] link_credit,
  input logic                link_valid,
  input logic                link_return,
  input logic [CNT_W-1:0]    occ,
  input logic [CNT_W-1:0]    owed
);

  assert_grant_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_update |-> (link_credit != '0) && (link_credit <= CREDIT_W'(CREDIT_MAX)));

  assert_count_balance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(src_credits) == int'($past(src_credits))
      + ($past(link_update) ? int'($past(link_credit)) : 0)
      - int'($past(link_valid)) - int'($past(link_return)));

  assert_no_send_without_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> (src_credits != '0) && src_in_valid);

  assert_return_needs_spare_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_return |-> (int'(src_credits) > int'(link_valid)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ) + int'(owed)) <= DEPTH);

endmodule

bind credit_stream_link credit_stream_link_chk #(
  .DEPTH(DEPTH), .CREDIT_MAX(CREDIT_MAX), .CNT_W(CNT_W), .CREDIT_W(CREDIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in_valid(src_in_valid), .src_credits(src_credits),
  .link_update(link_update), .link_credit(link_credit), .link_valid(link_valid),
  .link_return(link_return), .occ(occ), .owed(owed)
);

// File: tb/credit_stream_link_tb.sv
`timescale 1ns/1ps
module credit_stream_link_tb;
  localparam int DATA_W = 16;
  localparam int CNT_W = 4;
  localparam int CREDIT_W = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic src_in_valid = 0, src_give_back = 0, snk_out_pop = 0;
  logic [DATA_W-1:0] src_in_data = '0;
  logic src_in_accept, link_update, link_valid, link_return, snk_out_valid;
  logic [CNT_W-1:0] src_credits;
  logic [CREDIT_W-1:0] link_credit;
  logic [DATA_W-1:0] snk_out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  credit_stream_link u_dut (
    .clk(clk), .rst_n(rst_n), .src_in_valid(src_in_valid), .src_in_data(src_in_data),
    .src_in_accept(src_in_accept), .src_give_back(src_give_back), .src_credits(src_credits),
    .link_update(link_update), .link_credit(link_credit), .link_valid(link_valid),
    .link_return(link_return), .snk_out_valid(snk_out_valid), .snk_out_data(snk_out_data),
    .snk_out_pop(snk_out_pop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle counter arithmetic monitor
  bit have_prev = 0;
  int p_cnt, p_gain, p_v, p_r;
  always @(negedge clk) begin
    #3;
    if (rst_n && have_prev)
      chk(int'(src_credits) == p_cnt + p_gain - p_v - p_r, "R3",
          int'(src_credits), p_cnt + p_gain - p_v - p_r);
    p_cnt  = int'(src_credits);
    p_gain = link_update ? int'(link_credit) : 0;
    p_v    = int'(link_valid);
    p_r    = int'(link_return);
    have_prev = rst_n;
  end

  task automatic do_reset(input bit valid_at_release);
    rst_n = 0; src_in_valid = 0; src_give_back = 0; snk_out_pop = 0; src_in_data = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(src_credits == 0, "R1", int'(src_credits), 0);
    chk(!link_valid && !link_update && !snk_out_valid, "R1",
        int'({link_valid, link_update, snk_out_valid}), 0);
    @(negedge clk);
    rst_n = 1;
    src_in_valid = valid_at_release;
    #2;
    chk(link_update && link_credit == 4, "R2", int'(link_credit), 4);
  endtask

  task automatic settle();
    @(negedge clk); #2;
    chk(src_credits == 4, "R2", int'(src_credits), 4);
    chk(link_update && link_credit == 4, "R2", int'(link_credit), 4);
    @(negedge clk); #2;
    chk(src_credits == 8, "R2", int'(src_credits), 8);
    chk(!link_update, "R2", int'(link_update), 0);
  endtask

  task automatic t_zero_credit();
    do_reset(1'b1);
    chk(!link_valid, "R4", int'(link_valid), 0);
    @(negedge clk); #2;
    chk(link_valid && src_credits == 4, "R4", int'(src_credits), 4);
    chk(src_in_accept == link_valid, "R8", int'(src_in_accept), int'(link_valid));
    @(negedge clk); src_in_valid = 0;
  endtask

  task automatic t_fill_drain();
    do_reset(1'b0);
    settle();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      src_in_valid = 1; src_in_data = DATA_W'(16'hA000 + i);
      #2;
      if (i < 8) chk(src_in_accept, "R4", int'(src_in_accept), 1);
      else begin
        chk(!link_valid, "R4", int'(link_valid), 0);
        chk(!link_update, "R6", int'(link_update), 0);
      end
    end
    @(negedge clk); src_in_valid = 0; src_give_back = 1; #2;
    chk(!link_return, "R5", int'(link_return), 0);
    @(negedge clk); src_give_back = 0; #2;
    chk(src_credits == 0, "R5", int'(src_credits), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); snk_out_pop = 1; #2;
      chk(snk_out_valid && snk_out_data == DATA_W'(16'hA000 + i), "R7",
          int'(snk_out_data), 16'hA000 + i);
    end
    @(negedge clk); #2;
    chk(!snk_out_valid, "R7", int'(snk_out_valid), 0);
    @(negedge clk); #2;
    chk(!snk_out_valid, "R7", int'(snk_out_valid), 0);
    snk_out_pop = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(src_credits == 8, "R6", int'(src_credits), 8);
  endtask

  task automatic t_return();
    do_reset(1'b0);
    settle();
    @(negedge clk); src_give_back = 1; #2;
    chk(link_return, "R5", int'(link_return), 1);
    @(negedge clk); src_give_back = 0; #2;
    chk(src_credits == 7, "R5", int'(src_credits), 7);
    chk(link_update && link_credit == 1, "R2", int'(link_credit), 1);
    @(negedge clk); #2;
    chk(src_credits == 8, "R2", int'(src_credits), 8);
    @(negedge clk); src_in_valid = 1; src_give_back = 1; #2;
    chk(link_valid && link_return, "R5", int'({link_valid, link_return}), 3);
    @(negedge clk); src_in_valid = 0; src_give_back = 0; #2;
    chk(src_credits == 6, "R3", int'(src_credits), 6);
  endtask

  task automatic t_stream();
    int acc = 0, rx = 0;
    do_reset(1'b0);
    settle();
    snk_out_pop = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      src_in_valid = 1; src_in_data = DATA_W'(i);
      #2;
      if (src_in_accept) acc++;
      if (snk_out_valid) begin
        chk(snk_out_data == DATA_W'(rx), "R7", int'(snk_out_data), rx);
        rx++;
      end
    end
    chk(acc == 24, "R8", acc, 24);
    chk(rx == 23, "R8", rx, 23);
    @(negedge clk); src_in_valid = 0;
    repeat (4) @(negedge clk);
    #2;
    chk(src_credits == 8 && !snk_out_valid, "R6", int'(src_credits), 8);
    snk_out_pop = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_zero_credit();
    t_fill_drain();
    t_return();
    t_stream();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule